// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This block is a bus-slave peripheral that gives a host three 8-bit general-purpose ports and one configuration register. Access is over an 8-bit data path with active-low select, read and write strobes and a 2-bit register address. The host first writes a configuration word that sets each port's direction: port A, port B, and the upper and lower 4-bit halves of port C. It then writes output data or reads input data through the port addresses. Only plain latched input/output operation is provided.

Output data is held in latches and driven onto the pins. Each pin also has its own output-enable bit, so the pad ring can build tri-state buffers outside the block and no bidirectional net exists inside it. Port C is treated as two independent 4-bit halves. Each half has its own latch and its own direction bit, so one half can read sensors while the other drives strobes. After reset every port is an input and all output-enables are low, so no pin is driven until software asks for it.

A write is captured on the rising clock edge during which select and write strobe are both low. Its effect is visible at the ports from that edge on. Read data is combinational from the current state and the pins.

Top module: `tri_port_io`

## Requirements
- R1: After reset the configuration register holds 9Bh, every output-enable bit is 0 and every output latch is 0.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the configuration register, for both reads and writes.
- R3: In an accepted configuration word, bit 4 sets port A direction, bit 3 the upper half of port C (pins 7..4), bit 1 port B and bit 0 the lower half of port C (pins 3..0). A 1 makes the group an input and drives its output-enables to 0. A 0 makes it an output and drives its output-enables to all ones, from the edge that captures the word.
- R4: A write to address 3 with bit 7 clear is ignored: the configuration, every latch and every output-enable keep their values.
- R5: An accepted configuration word (bit 7 set) clears all four output latches to zero.
- R6: A write to a port group configured as output stores the data in its latch, which appears on that group's output pins from the capturing edge.
- R7: A write to a port group configured as input leaves that group's latch, and so its output pins, unchanged.
- R8: A read of a port returns the input pin values for groups configured as input and the latch values for groups configured as output, chosen per half for port C.
- R9: The read data bus is zero whenever select or read strobe is high.
- R10: No write takes effect while select is high, whatever the write strobe does.
- R11: A read of address 3 returns the last accepted configuration word, all 8 bits.
- R12: Configuration word 80h turns all three ports, both halves of port C included, into outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data from host |
| rdData | output | 8 | Read data to host, zero when not reading |
| portAIn | input | 8 | Port A pin inputs |
| portAOut | output | 8 | Port A output latch |
| portAOe | output | 8 | Port A per-bit output enable |
| portBIn | input | 8 | Port B pin inputs |
| portBOut | output | 8 | Port B output latch |
| portBOe | output | 8 | Port B per-bit output enable |
| portCIn | input | 8 | Port C pin inputs |
| portCOut | output | 8 | Port C output latches (upper and lower halves) |
| portCOe | output | 8 | Port C per-bit output enable |

## Verification
A corrupted configuration register shows at once on the output-enable pins in the cycle after the bad write. It also shows in the configuration readback and in which source a port read returns. A latch that was written when it should not have been, or not cleared by a new configuration word, shows on its output pins in the same cycle. Reading the port then returns the wrong value. Because the bench tracks the configuration, the four latches and the pins, each bus operation is compared against the expected state, and a divergence is reported within one access.

// File: rtl/tri_port_pkg.sv
`timescale 1ns/1ps
package tri_port_pkg;
  localparam int BUS_W  = 8;
  localparam int HALF_W = BUS_W / 2;
  localparam int ADDR_W = 2;

  // configuration word bit positions
  localparam int CW_VALID   = 7;
  localparam int CW_DIR_A   = 4;
  localparam int CW_DIR_CHI = 3;
  localparam int CW_DIR_B   = 1;
  localparam int CW_DIR_CLO = 0;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } regSel_t;

  typedef struct packed {
    logic    wrA;
    logic    wrB;
    logic    wrC;
    logic    wrCtrl;
    logic    rdEn;
    regSel_t rdSel;
  } busStrobe_t;
endpackage

// File: rtl/tri_port_busctl.sv
`timescale 1ns/1ps
module tri_port_busctl
  import tri_port_pkg::*;
(
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cwValid,
  output busStrobe_t        strb
);
  logic wrActive;
  regSel_t sel;

  assign wrActive = !csN && !wrN;
  assign sel      = regSel_t'(addr);

  always_comb begin
    strb        = '0;
    strb.rdEn   = !csN && !rdN;
    strb.rdSel  = sel;
    if (wrActive) begin
      unique case (sel)
        SEL_A:    strb.wrA    = 1'b1;
        SEL_B:    strb.wrB    = 1'b1;
        SEL_C:    strb.wrC    = 1'b1;
        SEL_CTRL: strb.wrCtrl = cwValid;
        default:  strb.wrA    = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tri_port_lane.sv
`timescale 1ns/1ps
module tri_port_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         clrEn,
  input  logic         isInput,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] pinOut,
  output logic [W-1:0] pinOe,
  output logic [W-1:0] rdVal
);
  logic [W-1:0] latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 latchQ <= '0;
    else if (clrEn)            latchQ <= '0;
    else if (wrEn && !isInput) latchQ <= wrData;
  end

  assign pinOut = latchQ;
  assign pinOe  = {W{!isInput}};
  assign rdVal  = isInput ? pinIn : latchQ;
endmodule

// File: rtl/tri_port_dp.sv
`timescale 1ns/1ps
module tri_port_dp
  import tri_port_pkg::*;
#(
  parameter logic [BUS_W-1:0] RESET_CTRL = 8'h9B
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strb,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] rdData,
  input  logic [BUS_W-1:0] portAIn,
  output logic [BUS_W-1:0] portAOut,
  output logic [BUS_W-1:0] portAOe,
  input  logic [BUS_W-1:0] portBIn,
  output logic [BUS_W-1:0] portBOut,
  output logic [BUS_W-1:0] portBOe,
  input  logic [BUS_W-1:0] portCIn,
  output logic [BUS_W-1:0] portCOut,
  output logic [BUS_W-1:0] portCOe
);
  logic [BUS_W-1:0] ctrlReg;
  logic [BUS_W-1:0] rdA, rdB, rdC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctrlReg <= RESET_CTRL;
    else if (strb.wrCtrl) ctrlReg <= wrData;
  end

  tri_port_lane #(.W(BUS_W)) u_laneA (
    .clk(clk), .rstN(rstN), .wrEn(strb.wrA), .clrEn(strb.wrCtrl),
    .isInput(ctrlReg[CW_DIR_A]), .wrData(wrData), .pinIn(portAIn),
    .pinOut(portAOut), .pinOe(portAOe), .rdVal(rdA)
  );

  tri_port_lane #(.W(BUS_W)) u_laneB (
    .clk(clk), .rstN(rstN), .wrEn(strb.wrB), .clrEn(strb.wrCtrl),
    .isInput(ctrlReg[CW_DIR_B]), .wrData(wrData), .pinIn(portBIn),
    .pinOut(portBOut), .pinOe(portBOe), .rdVal(rdB)
  );

  for (genvar h = 0; h < 2; h++) begin : g_cHalf
    localparam int DIR_BIT = (h == 0) ? CW_DIR_CLO : CW_DIR_CHI;
    tri_port_lane #(.W(HALF_W)) u_laneC (
      .clk(clk), .rstN(rstN), .wrEn(strb.wrC), .clrEn(strb.wrCtrl),
      .isInput(ctrlReg[DIR_BIT]),
      .wrData(wrData[h*HALF_W +: HALF_W]),
      .pinIn(portCIn[h*HALF_W +: HALF_W]),
      .pinOut(portCOut[h*HALF_W +: HALF_W]),
      .pinOe(portCOe[h*HALF_W +: HALF_W]),
      .rdVal(rdC[h*HALF_W +: HALF_W])
    );
  end

  always_comb begin
    rdData = '0;
    if (strb.rdEn) begin
      unique case (strb.rdSel)
        SEL_A:    rdData = rdA;
        SEL_B:    rdData = rdB;
        SEL_C:    rdData = rdC;
        SEL_CTRL: rdData = ctrlReg;
        default:  rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/tri_port_io.sv
`timescale 1ns/1ps
module tri_port_io
  import tri_port_pkg::*;
#(
  parameter logic [7:0] RESET_CTRL = 8'h9B
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [7:0] portAIn,
  output logic [7:0] portAOut,
  output logic [7:0] portAOe,
  input  logic [7:0] portBIn,
  output logic [7:0] portBOut,
  output logic [7:0] portBOe,
  input  logic [7:0] portCIn,
  output logic [7:0] portCOut,
  output logic [7:0] portCOe
);
  busStrobe_t strb;

  tri_port_busctl u_busctl (
    .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .cwValid(wrData[CW_VALID]), .strb(strb)
  );

  tri_port_dp #(.RESET_CTRL(RESET_CTRL)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(portCIn), .portCOut(portCOut), .portCOe(portCOe)
  );
endmodule

// File: rtl/tri_port_chk.sv
`timescale 1ns/1ps
module tri_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       rdN,
  input logic       wrN,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [7:0] portAOut,
  input logic [7:0] portAOe,
  input logic [7:0] portBOut,
  input logic [7:0] portBOe,
  input logic [7:0] portCOut,
  input logic [7:0] portCOe
);
  logic cfgWrite, badCfgWrite, portAWrite;
  assign cfgWrite    = !csN && !wrN && addr == 2'd3 && wrData[7];
  assign badCfgWrite = !csN && !wrN && addr == 2'd3 && !wrData[7];
  assign portAWrite  = !csN && !wrN && addr == 2'd0;

  // R9: bus idle means zero read data
  p_idle_bus_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> rdData == 8'h00);

  // R3: enables are uniform across each direction group
  p_oe_uniform_r3: assert property (@(posedge clk) disable iff (!rstN)
    (portAOe == 8'h00 || portAOe == 8'hFF) && (portBOe == 8'h00 || portBOe == 8'hFF)
    && (portCOe[7:4] == 4'h0 || portCOe[7:4] == 4'hF)
    && (portCOe[3:0] == 4'h0 || portCOe[3:0] == 4'hF));

  // R5: accepted configuration word clears all latches
  p_cfg_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (portAOut == 8'h00 && portBOut == 8'h00 && portCOut == 8'h00));

  // R4: configuration word with bit 7 clear changes nothing
  p_bad_cfg_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    badCfgWrite |=> ($stable(portAOe) && $stable(portBOe) && $stable(portCOe)
                     && $stable(portAOut) && $stable(portBOut) && $stable(portCOut)));

  // R10: deselected bus writes nothing
  p_cs_high_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> ($stable(portAOut) && $stable(portBOut) && $stable(portCOut)
             && $stable(portAOe) && $stable(portBOe) && $stable(portCOe)));

  // R6: write to output port A lands on its pins
  p_write_a_r6: assert property (@(posedge clk) disable iff (!rstN)
    (portAWrite && portAOe == 8'hFF) |=> portAOut == $past(wrData));
endmodule

bind tri_port_io tri_port_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
  .wrData(wrData), .rdData(rdData),
  .portAOut(portAOut), .portAOe(portAOe), .portBOut(portBOut), .portBOe(portBOe),
  .portCOut(portCOut), .portCOe(portCOe)
);

// File: tb/sim_tri_port_io.sv
`timescale 1ns/1ps
module sim_tri_port_io;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] portAIn = 8'h00, portBIn = 8'h00, portCIn = 8'h00;
  logic [7:0] portAOut, portAOe, portBOut, portBOe, portCOut, portCOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] mCtrl = 8'h9B;
  logic [7:0] mA = 8'h00, mB = 8'h00;
  logic [3:0] mChi = 4'h0, mClo = 4'h0;

  always #2 clk = ~clk;

  tri_port_io u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .wrData(wrData), .rdData(rdData),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(portCIn), .portCOut(portCOut), .portCOe(portCOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mCtrl[4] ? portAIn : mA;
      2'd1: return mCtrl[1] ? portBIn : mB;
      2'd2: return {mCtrl[3] ? portCIn[7:4] : mChi, mCtrl[0] ? portCIn[3:0] : mClo};
      default: return mCtrl;
    endcase
  endfunction

  task automatic modelWrite(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: if (!mCtrl[4]) mA = d;
      2'd1: if (!mCtrl[1]) mB = d;
      2'd2: begin
        if (!mCtrl[3]) mChi = d[7:4];
        if (!mCtrl[0]) mClo = d[3:0];
      end
      default: if (d[7]) begin
        mCtrl = d; mA = 0; mB = 0; mChi = 0; mClo = 0;
      end
    endcase
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    addr = a; wrData = d; csN = !sel; wrN = 1'b0;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
    if (sel) modelWrite(a, d);
  endtask

  task automatic checkPins(input string req);
    logic [7:0] eAOe, eBOe, eCOe;
    eAOe = {8{~mCtrl[4]}};
    eBOe = {8{~mCtrl[1]}};
    eCOe = {{4{~mCtrl[3]}}, {4{~mCtrl[0]}}};
    check(portAOe == eAOe, {req, " AOe"}, portAOe, eAOe);
    check(portBOe == eBOe, {req, " BOe"}, portBOe, eBOe);
    check(portCOe == eCOe, {req, " COe"}, portCOe, eCOe);
    check(portAOut == mA, {req, " AOut"}, portAOut, mA);
    check(portBOut == mB, {req, " BOut"}, portBOut, mB);
    check(portCOut == {mChi, mClo}, {req, " COut"}, portCOut, {mChi, mClo});
  endtask

  task automatic busRead(input logic [1:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    addr = a; csN = 1'b0; rdN = 1'b0;
    #1;
    e = expRead(a);
    check(rdData == e, req, rdData, e);
    rdN = 1'b1;
    #0.5;
    check(rdData == 8'h00, "R9 idle read bus", rdData, 8'h00);
    csN = 1'b1;
  endtask

  task automatic setPins(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    @(negedge clk);
    portAIn = a; portBIn = b; portCIn = c;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    checkPins("R1 reset");
    busRead(2'd3, "R1 reset ctrl 9Bh");
    // R8/R2: input reads on each address
    setPins(8'h5A, 8'hC1, 8'h3E);
    busRead(2'd0, "R2 R8 read A input");
    busRead(2'd1, "R2 R8 read B input");
    busRead(2'd2, "R2 R8 read C input");
    // R7: write to input port does not latch
    busWrite(2'd0, 8'h33, 1'b1);
    checkPins("R7 write to input A");
    // R4: ctrl write with bit7 clear ignored
    busWrite(2'd3, 8'h00, 1'b1);
    checkPins("R4 bad ctrl");
    busRead(2'd3, "R4 ctrl unchanged");
    // R12: all outputs
    busWrite(2'd3, 8'h80, 1'b1);
    checkPins("R12 all outputs");
    busRead(2'd3, "R11 ctrl readback 80h");
    // R6: latch output data per address
    busWrite(2'd0, 8'hC3, 1'b1);
    busWrite(2'd1, 8'h96, 1'b1);
    busWrite(2'd2, 8'h4D, 1'b1);
    checkPins("R6 R2 output latches");
    busRead(2'd0, "R8 read A latch");
    busRead(2'd2, "R8 read C latch");
    // R10: deselected write
    busWrite(2'd1, 8'h11, 1'b0);
    checkPins("R10 cs high write");
    // R5: new configuration clears latches
    busWrite(2'd3, 8'h89, 1'b1);
    checkPins("R5 clear on ctrl");
    // R3: mixed port C halves: upper out, lower in
    busWrite(2'd3, 8'h81, 1'b1);
    busWrite(2'd2, 8'hA5, 1'b1);
    setPins(8'h00, 8'h00, 8'h3C);
    checkPins("R3 mixed C halves");
    busRead(2'd2, "R3 R8 mixed C read");
    busWrite(2'd3, 8'h88, 1'b1);
    busWrite(2'd2, 8'h7E, 1'b1);
    checkPins("R3 lower out upper in");
    busRead(2'd2, "R3 R8 C read upper in");
    busRead(2'd3, "R11 ctrl readback 88h");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if (($urandom % 8) == 0) setPins(8'($urandom), 8'($urandom), 8'($urandom));
      busWrite(a, d, ($urandom % 6) != 0);
      checkPins("R3 R5 R6 R7 random");
      busRead(2'($urandom_range(0, 3)), "R8 R11 random read");
    end
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule